// File: doc/BRIEF.md
# UART Register and Buffer Front End

This block sits between a simple word-addressed register bus and the serial transmit and receive cores of a UART. Software writes characters into a data register, which queues them in a transmit FIFO. The FIFO presents them to the transmitter core through a valid/ready port. The receiver core hands in characters, each with a small field of error flags, through a second valid/ready port. Those characters are buffered in a receive FIFO. Software pops them by reading the same data register.

A flag register reports the FIFO fill state, line busy and the clear-to-send input. A line register holds the FIFO enable. A control register holds the global, transmit and receive enables, an internal loopback switch, and request-to-send controls. The serial shift logic is outside this block. Only the serial lines pass through it, so that loopback can be switched here. Modem bits that are not built here read back as zero.

Top module: `uart_regfront`

Register word addresses: 0 data, 1 flags, 2 line, 3 control.

## Requirements
- R1: After reset the control and line registers read 0, and the flag register reads 0x0090 with `cts_i` low (both FIFOs empty). `rts_o` is low.
- R2: The flag register bits are: bit 0 = `cts_i`, bit 3 = busy, bit 4 = receive empty, bit 5 = transmit full, bit 6 = receive full, bit 7 = transmit empty. All other bits are 0.
- R3: With line bit 4 set, writes to the data register queue up to DEPTH characters (bits 7:0). They are offered on `tx_data_o` in write order. A write while transmit-full is set is dropped.
- R4: A data read returns the oldest received character as {4'b0, error[3:0], byte[7:0]} and removes it. A read while receive-empty is set removes nothing.
- R5: With line bit 4 clear, each direction holds a single character, and the full flag sets after one entry.
- R6: A line write that clears bit 4 while it was set empties the transmit FIFO.
- R7: `tx_valid_o` is low unless control bits 0 and 8 are both set. `rx_ready_o` is low unless control bits 0 and 9 are both set. Without `rx_ready_o`, no character is stored.
- R8: With control bit 7 set, `rx_ser_o` follows `tx_ser_i` and `txd_o` is 1. Otherwise `rx_ser_o` follows `rxd_i` and `txd_o` follows `tx_ser_i`.
- R9: With control bit 14 set, `rts_o` is high exactly when the receive FIFO is not full. Otherwise `rts_o` equals control bit 11.
- R10: With control bit 15 set, `tx_valid_o` stays low while `cts_i` is low.
- R11: The control register keeps only bits 0, 7, 8, 9, 11, 14 and 15, and the line register keeps only bit 4. All other bits read 0.
- R12: The busy flag is set while the transmit FIFO holds a character or `tx_busy_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| tx_valid_o | output | 1 | Character offered to the transmitter |
| tx_data_o | output | 8 | Character to transmit |
| tx_ready_i | input | 1 | Transmitter takes the character |
| tx_busy_i | input | 1 | Transmitter is shifting |
| rx_valid_i | input | 1 | Receiver has a character |
| rx_data_i | input | 8 | Received character |
| rx_err_i | input | 4 | Error flags of that character |
| rx_ready_o | output | 1 | Character is accepted |
| tx_ser_i | input | 1 | Serial output of the transmitter core |
| rx_ser_o | output | 1 | Serial input to the receiver core |
| txd_o | output | 1 | External transmit line |
| rxd_i | input | 1 | External receive line |
| cts_i | input | 1 | Clear-to-send input |
| rts_o | output | 1 | Request-to-send output |

## Verification
If a FIFO pointer or count goes wrong, it shows on the next flag read or the next transmit handshake. Characters may come out of order or repeated, the full flag may set at the wrong fill level, or the empty flag may stay set after a write. A wrong control register shows in the same cycle on the gated valid/ready ports, the serial multiplexer and `rts_o`. A missed flush appears as a transmit-empty flag still low on the read straight after the line write.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned ERR_W  = 4;

  typedef enum logic [1:0] {
    RA_DATA = 2'd0,
    RA_FLAG = 2'd1,
    RA_LINE = 2'd2,
    RA_CTRL = 2'd3
  } reg_addr_e;

  // control bit positions
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_LOOP   = 7;
  localparam int unsigned CB_TXE    = 8;
  localparam int unsigned CB_RXE    = 9;
  localparam int unsigned CB_RTS    = 11;
  localparam int unsigned CB_RTSFLW = 14;
  localparam int unsigned CB_CTSFLW = 15;
  localparam logic [BUS_W-1:0] CTRL_MASK = 16'hCB81;

  // line bit position
  localparam int unsigned LB_FEN = 4;
endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single_i,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             wr_ok, rd_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = single_i ? (cnt_q != '0) : (cnt_q == CNT_MAX);
  assign rdata_o = mem_q[rptr_q];
  assign wr_ok   = push_i && !full_o && !flush_i;
  assign rd_ok   = pop_i && !empty_o && !flush_i;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush_i) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (wr_ok) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
      if (rd_ok) rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wptr_q] <= wdata_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(cnt_q)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> empty_o); // R6
  AST_SINGLE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (single_i && !empty_o) |-> full_o); // R5
endmodule

// File: rtl/uart_rf_regs.sv
module uart_rf_regs
  import uart_regfront_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_line_i,
  input  logic             wr_ctrl_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] ctrl_o,
  output logic             fen_o,
  output logic             tx_flush_o
);
  logic [BUS_W-1:0] ctrl_q, ctrl_d;
  logic             fen_q, fen_d;

  always_comb begin
    ctrl_d = ctrl_q;
    fen_d  = fen_q;
    if (wr_ctrl_i) ctrl_d = wdata_i & CTRL_MASK;
    if (wr_line_i) fen_d  = wdata_i[LB_FEN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fen_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      fen_q  <= fen_d;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign fen_o      = fen_q;
  assign tx_flush_o = wr_line_i && fen_q && !wdata_i[LB_FEN];

  AST_FLUSH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_o |=> !fen_o); // R6
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              tx_valid_o,
  output logic [CHAR_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  input  logic              tx_busy_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  output logic              rx_ready_o,
  input  logic              tx_ser_i,
  output logic              rx_ser_o,
  output logic              txd_o,
  input  logic              rxd_i,
  input  logic              cts_i,
  output logic              rts_o
);
  localparam int unsigned RXW = CHAR_W + ERR_W;

  logic             rst_m_q, rst_s_q;
  logic [BUS_W-1:0] ctrl;
  logic             fen, tx_flush;
  logic             wr_data, wr_line, wr_ctrl, rd_data;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic [RXW-1:0]   rx_head;
  logic             tx_go, rx_go, tx_pop;
  logic [BUS_W-1:0] flag_word;
  logic             unused_wdata;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  assign wr_data = bus_sel && bus_wr  && (bus_addr == RA_DATA);
  assign wr_line = bus_sel && bus_wr  && (bus_addr == RA_LINE);
  assign wr_ctrl = bus_sel && bus_wr  && (bus_addr == RA_CTRL);
  assign rd_data = bus_sel && !bus_wr && (bus_addr == RA_DATA);
  assign unused_wdata = &{1'b0, bus_wdata[BUS_W-1:CHAR_W]};

  uart_rf_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .wr_line_i  (wr_line),
    .wr_ctrl_i  (wr_ctrl),
    .wdata_i    (bus_wdata),
    .ctrl_o     (ctrl),
    .fen_o      (fen),
    .tx_flush_o (tx_flush)
  );

  assign tx_go = ctrl[CB_EN] && ctrl[CB_TXE] && (!ctrl[CB_CTSFLW] || cts_i);
  assign rx_go = ctrl[CB_EN] && ctrl[CB_RXE];

  assign tx_valid_o = tx_go && !tx_empty;
  assign tx_pop     = tx_valid_o && tx_ready_i;
  assign rx_ready_o = rx_go && !rx_full;

  uart_rf_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_txq (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .single_i (!fen),
    .flush_i  (tx_flush),
    .push_i   (wr_data),
    .wdata_i  (bus_wdata[CHAR_W-1:0]),
    .pop_i    (tx_pop),
    .rdata_o  (tx_data_o),
    .empty_o  (tx_empty),
    .full_o   (tx_full)
  );

  uart_rf_fifo #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .single_i (!fen),
    .flush_i  (1'b0),
    .push_i   (rx_valid_i && rx_ready_o),
    .wdata_i  ({rx_err_i, rx_data_i}),
    .pop_i    (rd_data),
    .rdata_o  (rx_head),
    .empty_o  (rx_empty),
    .full_o   (rx_full)
  );

  // serial path and flow control
  assign rx_ser_o = ctrl[CB_LOOP] ? tx_ser_i : rxd_i;
  assign txd_o    = ctrl[CB_LOOP] ? 1'b1 : tx_ser_i;
  assign rts_o    = ctrl[CB_RTSFLW] ? !rx_full : ctrl[CB_RTS];

  always_comb begin
    flag_word    = '0;
    flag_word[0] = cts_i;
    flag_word[3] = tx_busy_i || !tx_empty;
    flag_word[4] = rx_empty;
    flag_word[5] = tx_full;
    flag_word[6] = rx_full;
    flag_word[7] = tx_empty;
  end

  always_comb begin
    case (bus_addr)
      RA_DATA: bus_rdata = BUS_W'(rx_head);
      RA_FLAG: bus_rdata = flag_word;
      RA_LINE: bus_rdata = BUS_W'({fen, 4'b0000});
      default: bus_rdata = ctrl;
    endcase
  end

  AST_TX_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_s_q)
    (ctrl[CB_CTSFLW] && !cts_i) |-> !tx_valid_o); // R10
  AST_RTS_ON_FULL: assert property (@(posedge clk) disable iff (!rst_s_q)
    (ctrl[CB_RTSFLW] && rx_full) |-> !rts_o); // R9
  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_s_q)
    (rx_valid_i && !rx_ready_o && !rd_data) |=> $stable(rx_empty)); // R7
  AST_LOOP_IDLE: assert property (@(posedge clk) disable iff (!rst_s_q)
    (ctrl[CB_LOOP] && $stable(ctrl)) |-> (txd_o && (rx_ser_o == tx_ser_i))); // R8
endmodule

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        tx_valid_o, tx_ready_i = 1'b0, tx_busy_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        rx_valid_i = 1'b0, rx_ready_o;
  logic [7:0]  rx_data_i = 8'd0;
  logic [3:0]  rx_err_i = 4'd0;
  logic        tx_ser_i = 1'b1, rx_ser_o, txd_o, rxd_i = 1'b1;
  logic        cts_i = 1'b0, rts_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_regfront #(.DEPTH(DEPTH)) u_uart_regfront (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
    .tx_busy_i(tx_busy_i), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .rx_err_i(rx_err_i), .rx_ready_o(rx_ready_o), .tx_ser_i(tx_ser_i),
    .rx_ser_o(rx_ser_o), .txd_o(txd_o), .rxd_i(rxd_i), .cts_i(cts_i),
    .rts_o(rts_o)
  );

  // {write, addr[1:0], wdata[15:0], expected read[15:0]}
  localparam logic [34:0] VEC [0:9] = '{
    {1'b0, 2'd1, 16'h0000, 16'h0090},  // R1 flags after reset
    {1'b0, 2'd3, 16'h0000, 16'h0000},  // R1 control after reset
    {1'b0, 2'd2, 16'h0000, 16'h0000},  // R1 line after reset
    {1'b1, 2'd3, 16'hFFFF, 16'h0000},
    {1'b0, 2'd3, 16'h0000, 16'hCB81},  // R11 control keeps its bits only
    {1'b1, 2'd2, 16'hFFFF, 16'h0000},
    {1'b0, 2'd2, 16'h0000, 16'h0010},  // R11 line keeps bit 4 only
    {1'b1, 2'd3, 16'h0000, 16'h0000},
    {1'b1, 2'd2, 16'h0000, 16'h0000},
    {1'b0, 2'd1, 16'h0000, 16'h0090}   // R2 flag layout, idle
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rts_o", {15'd0, rts_o}, 16'd0);

    foreach (VEC[i]) begin
      if (VEC[i][34]) bus_write(VEC[i][33:32], VEC[i][31:16]);
      else begin
        bus_read(VEC[i][33:32], rd);
        check($sformatf("R1/R2/R11 vector %0d", i), rd, VEC[i][15:0]);
      end
    end

    // R5 single-entry mode, R7 disabled transmitter
    bus_write(2'd0, 16'h0041);
    bus_write(2'd0, 16'h0042);
    bus_read(2'd1, rd);
    check("R5 flags after one write (busy, full)", rd, 16'h0038);
    tx_ready_i = 1'b1;
    @(negedge clk);
    check("R7 tx_valid_o while disabled", {15'd0, tx_valid_o}, 16'd0);
    bus_write(2'd3, 16'h0101);
    check("R5 single char data", {8'd0, tx_data_o}, 16'h0041);
    check("R5 single char valid", {15'd0, tx_valid_o}, 16'd1);
    @(negedge clk);
    check("R5 second write dropped", {15'd0, tx_valid_o}, 16'd0);

    // R3 FIFO order and overflow drop
    tx_ready_i = 1'b0;
    bus_write(2'd3, 16'h0000);
    bus_write(2'd2, 16'h0010);
    for (int k = 0; k < DEPTH + 1; k++) bus_write(2'd0, 16'h0060 + 16'(k));
    bus_read(2'd1, rd);
    check("R3 transmit full flag", rd & 16'h00A0, 16'h0020);
    bus_write(2'd3, 16'h0101);
    tx_ready_i = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      check($sformatf("R3 order entry %0d", k), {7'd0, tx_valid_o, tx_data_o},
            16'h0160 + 16'(k));
      @(negedge clk);
    end
    check("R3 ninth write dropped", {15'd0, tx_valid_o}, 16'd0);
    tx_ready_i = 1'b0;

    // R10 clear-to-send gating
    bus_write(2'd3, 16'h8101);
    bus_write(2'd0, 16'h0077);
    check("R10 held while cts low", {15'd0, tx_valid_o}, 16'd0);
    cts_i = 1'b1;
    #1 check("R10 released by cts", {15'd0, tx_valid_o}, 16'd1);
    bus_read(2'd1, rd);
    check("R2 cts flag bit 0", rd & 16'h0001, 16'h0001);
    cts_i = 1'b0;

    // R6 flush on clearing FIFO enable
    bus_write(2'd3, 16'h0000);
    bus_write(2'd0, 16'h0011);
    bus_write(2'd0, 16'h0012);
    bus_write(2'd2, 16'h0000);
    bus_read(2'd1, rd);
    check("R6 transmit empty after flush", rd & 16'h00A8, 16'h0080);

    // R12 busy from the transmitter core
    tx_busy_i = 1'b1;
    bus_read(2'd1, rd);
    check("R12 busy with empty FIFO", rd & 16'h0008, 16'h0008);
    tx_busy_i = 1'b0;

    // R7 receiver disabled stores nothing
    @(negedge clk);
    rx_valid_i = 1'b1; rx_data_i = 8'h33; rx_err_i = 4'h0;
    #1 check("R7 rx_ready_o while disabled", {15'd0, rx_ready_o}, 16'd0);
    @(negedge clk);
    rx_valid_i = 1'b0;
    bus_read(2'd1, rd);
    check("R7 nothing stored", rd & 16'h0010, 16'h0010);

    // R4 receive with error bits, empty read pops nothing
    bus_write(2'd3, 16'h0201);
    @(negedge clk);
    rx_valid_i = 1'b1; rx_data_i = 8'h5A; rx_err_i = 4'h3;
    #1 check("R4 rx_ready_o enabled", {15'd0, rx_ready_o}, 16'd1);
    @(negedge clk);
    rx_valid_i = 1'b0;
    bus_read(2'd0, rd);
    check("R4 data with error field", rd, 16'h035A);
    bus_read(2'd1, rd);
    check("R4 empty after read", rd & 16'h0050, 16'h0010);
    bus_read(2'd0, rd);
    bus_read(2'd1, rd);
    check("R4 empty read harmless", rd & 16'h0050, 16'h0010);

    // R9 RTS flow control
    bus_write(2'd2, 16'h0010);
    bus_write(2'd3, 16'h4201);
    #1 check("R9 rts high with room", {15'd0, rts_o}, 16'd1);
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      rx_valid_i = 1'b1; rx_data_i = 8'(k);
    end
    @(negedge clk);
    rx_valid_i = 1'b0;
    #1 check("R9 rts low when full", {15'd0, rts_o}, 16'd0);
    bus_read(2'd1, rd);
    check("R2 receive full flag", rd & 16'h0050, 16'h0040);
    bus_write(2'd3, 16'h0801);
    #1 check("R9 rts follows bit 11 set", {15'd0, rts_o}, 16'd1);
    bus_write(2'd3, 16'h0001);
    #1 check("R9 rts follows bit 11 clear", {15'd0, rts_o}, 16'd0);

    // R8 loopback
    bus_write(2'd3, 16'h0081);
    tx_ser_i = 1'b0; rxd_i = 1'b1;
    #1 check("R8 loop rx_ser_o", {15'd0, rx_ser_o}, 16'd0);
    check("R8 loop txd_o idle", {15'd0, txd_o}, 16'd1);
    bus_write(2'd3, 16'h0000);
    #1 check("R8 normal txd_o", {15'd0, txd_o}, 16'd0);
    check("R8 normal rx_ser_o", {15'd0, rx_ser_o}, 16'd1);

    finish_run();
  end
endmodule